// File: doc/BRIEF.md
# Panel power-up sequencer

This block brings an LCD panel and its backlight out of the unpowered state in one fixed order. It walks seven stages: it selects the display pin function, then turns on the panel supply, the LVDS link, the backlight supply, the backlight PWM and the backlight enable, and finally reports completion. Each of the first four stages is followed by a settling time, given in milliseconds and counted on a microsecond tick. The next stage cannot start until that time has fully elapsed.

Software or a boot controller can drive the block in two ways. It can pulse `adv_req` repeatedly, and each pulse moves the sequence forward only if the current settling time has expired. Or it can hold `run_all`, and the block then runs unattended to the end, honouring every settling time. The board may leave out any of the four enable lines. A stage whose line is absent drives nothing, but the sequence still passes through it and still spends its settling time.

Top module: `panel_pwrup_seq`

## Requirements
- R1: After synchronous active-low reset, every output is low and the sequencer sits in the start stage. Without a request it stays there.
- R2: In the start stage, a request (`adv_req` or `run_all` high at a clock edge) is served at that edge without any wait. `mux_sel_pulse` is then high for exactly one cycle.
- R3: Stages fire in this fixed order: mux select, panel supply, LVDS, backlight supply, PWM start, backlight enable and done.
- R4: After the stage with index k fires, the next stage waits for `dly_ms[k*DLY_W +: DLY_W]` × `US_PER_MS` rising `us_tick` samples. The indexes are k=0 for mux select, 1 for panel supply, 2 for LVDS and 3 for backlight supply. When the tick is high on every cycle and a request is pending, the next stage's output changes exactly N+1 cycles after the previous one, where N is that tick count.
- R5: The PWM stage has no settling time. `bl_en` (when present) and `seq_done` rise exactly one cycle after the `pwm_start` strobe.
- R6: `line_present` marks which enable lines exist: bit0 is the panel supply, bit1 LVDS, bit2 the backlight supply and bit3 the backlight enable. If a bit is 0, that output never rises, yet the stage still takes its slot and its settling time.
- R7: Without `run_all`, an `adv_req` made before the settling time has expired is ignored. One made after it has expired fires the next stage at that edge.
- R8: While `run_all` is held, the sequence reaches `seq_done` without any further request.
- R9: The settling counter advances only on cycles where `us_tick` is high.
- R10: `pwm_start` is a single-cycle strobe. `pwm_freq_hz`, `pwm_duty` and `pwm_div` carry 32768, 0xDF and 1.
- R11: Once `seq_done` is high, requests cause no further pulse and no output change.
- R12: Each enable output and `seq_done` stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_req | input | 1 | Request to advance one stage if allowed |
| run_all | input | 1 | Hold high to run the whole sequence unattended |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| dly_ms | input | 4*DLY_W | Four settling times in ms, field k after stage k |
| line_present | input | 4 | Which optional enable lines exist |
| mux_sel_pulse | output | 1 | One-cycle display pin-function select |
| panel_vdd_en | output | 1 | Panel supply on |
| lvds_en | output | 1 | LVDS link enable |
| bl_vdd_en | output | 1 | Backlight supply on |
| pwm_start | output | 1 | One-cycle backlight PWM start strobe |
| pwm_freq_hz | output | FREQ_W | Requested PWM frequency |
| pwm_duty | output | DUTY_W | Requested PWM duty code |
| pwm_div | output | DIV_W | Requested PWM divider |
| bl_en | output | 1 | Backlight enable |
| seq_done | output | 1 | Sequence complete |

## Verification
The bench builds the block with its default parameters: `DLY_W` of 8, `US_PER_MS` of 1000 and the stated PWM request values. The real millisecond-to-microsecond scaling is therefore what gets checked. Settling times of 0 to 3 ms keep each run to a few thousand cycles. This brings the zero-delay boundary, mixed delays, every absent-line pattern and a tick held low within reach, each with cycle-exact spacing.

// File: rtl/pps_pkg.sv
// Shared stage encoding and line-to-stage mapping for the panel power-up
// sequencer. Assumes the stage order is fixed and never reconfigured.
package pps_pkg;

    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_PANEL = 3'd1,
        ST_LVDS  = 3'd2,
        ST_BLVDD = 3'd3,
        ST_PWM   = 3'd4,
        ST_BLEN  = 3'd5,
        ST_DONE  = 3'd6
    } pps_stage_e;

    localparam int NUM_LINES = 4;   // optional enable lines
    localparam int NUM_TIMED = 4;   // stages followed by a settling time

    // Stage at which optional line k is driven high.
    function automatic pps_stage_e line_stage(input int k);
        if (k == NUM_LINES - 1)
            return ST_BLEN;
        return pps_stage_e'(3'(k + 1));
    endfunction

endpackage

// File: rtl/pps_delay_timer.sv
// Settling-time down counter. Loaded with a tick count when a stage fires,
// decremented on each microsecond tick, reports zero when expired.
// Assumes load and tick never need to act in the same cycle (load wins).
module pps_delay_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    // Hold the remaining tick count of the current settling window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (tick && (remain != '0))
            remain <= remain - 1'b1;
    end

    // Window is over once the count has reached zero.
    always_comb expired = (remain == '0);

endmodule

// File: rtl/pps_stage_ctrl.sv
// Stage register and fire decision. The start stage fires on any request;
// later stages fire on a request once the settling timer has expired.
// Also selects the settling time to load after the stage now firing.
module pps_stage_ctrl
    import pps_pkg::*;
#(
    parameter int DLY_W     = 8,
    parameter int US_PER_MS = 1000,
    parameter int CNT_W     = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic                       timer_expired,
    input  logic [NUM_TIMED*DLY_W-1:0] dly_ms,
    output logic                       fire,
    output pps_stage_e                 stage,
    output logic [CNT_W-1:0]           load_val
);

    localparam logic [CNT_W-1:0] TICKS_PER_MS = CNT_W'(US_PER_MS);

    logic [1:0]       dly_idx;
    logic [DLY_W-1:0] dly_sel;

    // Decide whether the current stage executes at this edge.
    always_comb begin
        if (stage == ST_START)
            fire = req;
        else if (stage == ST_DONE)
            fire = 1'b0;
        else
            fire = req && timer_expired;
    end

    // Pick the millisecond field matching the stage that is firing.
    always_comb begin
        dly_idx  = stage[1:0];
        dly_sel  = dly_ms[dly_idx*DLY_W +: DLY_W];
        load_val = '0;
        if (stage <= ST_BLVDD)
            load_val = CNT_W'(dly_sel) * TICKS_PER_MS;
    end

    // Step to the following stage whenever the current one fires.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage <= ST_START;
        else if (fire)
            stage <= pps_stage_e'(stage + 3'd1);
    end

endmodule

// File: rtl/pps_out_drv.sv
// Output register bank. Turns the firing stage into level enables, the two
// single-cycle strobes and the done flag. Absent lines are never raised.
module pps_out_drv
    import pps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  pps_stage_e           stage,
    input  logic [NUM_LINES-1:0] line_present,
    output logic [NUM_LINES-1:0] line_on,
    output logic                 mux_pulse,
    output logic                 pwm_pulse,
    output logic                 done
);

    // Strobes last one cycle; done latches on the last enable stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_pulse <= 1'b0;
            pwm_pulse <= 1'b0;
            done      <= 1'b0;
        end else begin
            mux_pulse <= fire && (stage == ST_START);
            pwm_pulse <= fire && (stage == ST_PWM);
            if (fire && (stage == ST_BLEN))
                done <= 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        // Raise line k at its stage if the board has it; hold until reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                line_on[k] <= 1'b0;
            else if (fire && (stage == line_stage(k)) && line_present[k])
                line_on[k] <= 1'b1;
        end
    end

endmodule

// File: rtl/panel_pwrup_seq.sv
// Panel power-up sequencer top. Joins the stage controller, settling timer
// and output bank. Assumes us_tick is a one-cycle pulse per microsecond and
// that dly_ms/line_present are stable while the sequence runs.
module panel_pwrup_seq
    import pps_pkg::*;
#(
    parameter int          DLY_W       = 8,
    parameter int          US_PER_MS   = 1000,
    parameter int          FREQ_W      = 16,
    parameter int          DUTY_W      = 8,
    parameter int          DIV_W       = 4,
    parameter int          PWM_FREQ_HZ = 32768,
    parameter int          PWM_DUTY    = 8'hDF,
    parameter int          PWM_DIV     = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv_req,
    input  logic                   run_all,
    input  logic                   us_tick,
    input  logic [4*DLY_W-1:0]     dly_ms,
    input  logic [3:0]             line_present,
    output logic                   mux_sel_pulse,
    output logic                   panel_vdd_en,
    output logic                   lvds_en,
    output logic                   bl_vdd_en,
    output logic                   pwm_start,
    output logic [FREQ_W-1:0]      pwm_freq_hz,
    output logic [DUTY_W-1:0]      pwm_duty,
    output logic [DIV_W-1:0]       pwm_div,
    output logic                   bl_en,
    output logic                   seq_done
);

    localparam int CNT_W = DLY_W + $clog2(US_PER_MS);

    logic                 req;
    logic                 fire;
    logic                 timer_expired;
    pps_stage_e           stage;
    logic [CNT_W-1:0]     load_val;
    logic [NUM_LINES-1:0] line_on;

    // Either input style counts as a request to advance.
    always_comb req = adv_req || run_all;

    pps_stage_ctrl #(
        .DLY_W     (DLY_W),
        .US_PER_MS (US_PER_MS),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .timer_expired (timer_expired),
        .dly_ms        (dly_ms),
        .fire          (fire),
        .stage         (stage),
        .load_val      (load_val)
    );

    pps_delay_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire),
        .load_val (load_val),
        .tick     (us_tick),
        .expired  (timer_expired)
    );

    pps_out_drv u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (fire),
        .stage        (stage),
        .line_present (line_present),
        .line_on      (line_on),
        .mux_pulse    (mux_sel_pulse),
        .pwm_pulse    (pwm_start),
        .done         (seq_done)
    );

    // Map the generic line bank onto named enables.
    always_comb begin
        panel_vdd_en = line_on[0];
        lvds_en      = line_on[1];
        bl_vdd_en    = line_on[2];
        bl_en        = line_on[3];
    end

    // Fixed PWM request presented alongside the start strobe.
    always_comb begin
        pwm_freq_hz = FREQ_W'(PWM_FREQ_HZ);
        pwm_duty    = DUTY_W'(PWM_DUTY);
        pwm_div     = DIV_W'(PWM_DIV);
    end

endmodule

// File: rtl/pps_chk.sv
// Property checker for the panel power-up sequencer, bound to the top.
module pps_chk (
    input logic clk,
    input logic rst_n,
    input logic mux_sel_pulse,
    input logic panel_vdd_en,
    input logic lvds_en,
    input logic bl_vdd_en,
    input logic pwm_start,
    input logic bl_en,
    input logic seq_done
);

    a_r2_mux_single: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sel_pulse |=> !mux_sel_pulse);

    a_r10_pwm_single: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_start |=> !pwm_start);

    a_r12_panel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        panel_vdd_en |=> panel_vdd_en);

    a_r12_lvds_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lvds_en |=> lvds_en);

    a_r12_blvdd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bl_vdd_en |=> bl_vdd_en);

    a_r12_blen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bl_en |=> bl_en);

    a_r5_done_after_pwm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> $past(pwm_start));

    a_r3_pwm_before_blen: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_start |-> (!bl_en && !seq_done));

    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (seq_done && !mux_sel_pulse && !pwm_start));

endmodule

bind panel_pwrup_seq pps_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mux_sel_pulse (mux_sel_pulse),
    .panel_vdd_en  (panel_vdd_en),
    .lvds_en       (lvds_en),
    .bl_vdd_en     (bl_vdd_en),
    .pwm_start     (pwm_start),
    .bl_en         (bl_en),
    .seq_done      (seq_done)
);

// File: tb/panel_pwrup_seq_tb.sv
`timescale 1ns/1ps
module panel_pwrup_seq_tb;

    localparam int DLY_W = 8;
    localparam int TPM   = 1000;
    localparam int NROWS = 5;

    // {present[3:0], d0, d1, d2, d3} in ms
    localparam logic [35:0] ROWS [NROWS] = '{
        {4'b1111, 8'd0, 8'd0, 8'd0, 8'd0},
        {4'b1111, 8'd1, 8'd0, 8'd2, 8'd1},
        {4'b0101, 8'd0, 8'd2, 8'd1, 8'd0},
        {4'b1010, 8'd1, 8'd1, 8'd0, 8'd1},
        {4'b0000, 8'd2, 8'd0, 8'd0, 8'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv_req = 1'b0;
    logic run_all = 1'b0;
    logic us_tick = 1'b0;
    logic [4*DLY_W-1:0] dly_ms = '0;
    logic [3:0] line_present = '0;
    logic mux_sel_pulse, panel_vdd_en, lvds_en, bl_vdd_en, pwm_start, bl_en, seq_done;
    logic [15:0] pwm_freq_hz;
    logic [7:0]  pwm_duty;
    logic [3:0]  pwm_div;

    always #4 clk = ~clk;

    panel_pwrup_seq u_dut (
        .clk(clk), .rst_n(rst_n), .adv_req(adv_req), .run_all(run_all),
        .us_tick(us_tick), .dly_ms(dly_ms), .line_present(line_present),
        .mux_sel_pulse(mux_sel_pulse), .panel_vdd_en(panel_vdd_en),
        .lvds_en(lvds_en), .bl_vdd_en(bl_vdd_en), .pwm_start(pwm_start),
        .pwm_freq_hz(pwm_freq_hz), .pwm_duty(pwm_duty), .pwm_div(pwm_div),
        .bl_en(bl_en), .seq_done(seq_done)
    );

    wire [3:0] lines = {bl_en, bl_vdd_en, lvds_en, panel_vdd_en};

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit mon    = 0;
    int t_mux, t_pwm, t_done, cnt_mux, cnt_pwm;
    int t_line [4];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Record first-seen cycles of each output event.
    always @(negedge clk) begin
        if (mon) begin
            if (mux_sel_pulse) begin cnt_mux++; t_mux = cyc; end
            if (pwm_start) begin cnt_pwm++; t_pwm = cyc; end
            if (seq_done && t_done < 0) t_done = cyc;
            for (int k = 0; k < 4; k++)
                if (lines[k] && t_line[k] < 0) t_line[k] = cyc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        t_mux = -1; t_pwm = -1; t_done = -1; cnt_mux = 0; cnt_pwm = 0;
        for (int k = 0; k < 4; k++) t_line[k] = -1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; adv_req = 1'b0; run_all = 1'b0; us_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_adv();
        @(negedge clk); adv_req = 1'b1;
        @(negedge clk); adv_req = 1'b0;
    endtask

    initial begin
        clr_mon();
        // R1: reset state and idle without request
        do_reset();
        @(negedge clk);
        chk("R1 outputs after reset", {28'd0, mux_sel_pulse, lines, pwm_start, seq_done} != 0, 0);
        repeat (20) @(negedge clk);
        chk("R1 idle without request", {lines, mux_sel_pulse, pwm_start, seq_done}, 0);

        // Table walk: run_all held, tick every cycle
        for (int r = 0; r < NROWS; r++) begin
            int n [4];
            int f [6];
            logic [3:0] pres;
            pres = ROWS[r][35:32];
            for (int k = 0; k < 4; k++) n[k] = int'(ROWS[r][31-8*k -: 8]) * TPM;
            f[0] = 0;
            for (int k = 1; k <= 4; k++) f[k] = f[k-1] + n[k-1] + 1;
            f[5] = f[4] + 1;
            do_reset();
            clr_mon();
            mon = 1;
            line_present = pres;
            for (int k = 0; k < 4; k++) dly_ms[k*DLY_W +: DLY_W] = ROWS[r][31-8*k -: 8];
            us_tick = 1'b1;
            run_all = 1'b1;
            for (int w = 0; w < 20000 && !seq_done; w++) @(negedge clk);
            repeat (5) @(negedge clk);
            mon = 0;
            run_all = 1'b0;
            chk("R8 done reached with run_all", seq_done, 1);
            chk("R2 mux pulse count", cnt_mux, 1);
            chk("R10 pwm strobe count", cnt_pwm, 1);
            for (int k = 0; k < 4; k++) begin
                int fs;
                fs = (k == 3) ? f[5] : f[k+1];
                if (pres[k]) chk("R4 line rise spacing", t_line[k] - t_mux, fs);
                else         chk("R6 absent line stays low", t_line[k], -1);
            end
            chk("R3 pwm stage position", t_pwm - t_mux, f[4]);
            chk("R5 done one cycle after pwm", t_done - t_pwm, 1);
            chk("R12 enables held", lines, pres);
        end

        // R10: PWM request values
        chk("R10 pwm freq", pwm_freq_hz, 32768);
        chk("R10 pwm duty", pwm_duty, 8'hDF);
        chk("R10 pwm div", pwm_div, 1);

        // R11: requests after done change nothing
        begin
            logic [3:0] snap;
            snap = lines;
            clr_mon();
            mon = 1;
            pulse_adv();
            run_all = 1'b1;
            repeat (50) @(negedge clk);
            run_all = 1'b0;
            mon = 0;
            chk("R11 no pulses after done", cnt_mux + cnt_pwm, 0);
            chk("R11 outputs unchanged after done", lines, snap);
            chk("R11 done held", seq_done, 1);
        end

        // R2/R7: stepping by single requests, d0 = 1 ms
        do_reset();
        line_present = 4'hF;
        dly_ms = {8'd0, 8'd0, 8'd0, 8'd1};
        us_tick = 1'b1;
        pulse_adv();
        chk("R2 start fires without wait", mux_sel_pulse, 1);
        repeat (10) @(negedge clk);
        pulse_adv();
        repeat (3) @(negedge clk);
        chk("R7 early request ignored", panel_vdd_en, 0);
        repeat (1100) @(negedge clk);
        chk("R7 no advance without request", panel_vdd_en, 0);
        pulse_adv();
        chk("R7 late request advances", panel_vdd_en, 1);
        chk("R3 lvds not yet on", lvds_en, 0);

        // R9: timer frozen while tick low
        do_reset();
        us_tick = 1'b0;
        run_all = 1'b1;
        repeat (3000) @(negedge clk);
        chk("R9 no advance without ticks", panel_vdd_en, 0);
        us_tick = 1'b1;
        repeat (1100) @(negedge clk);
        chk("R9 advance once ticks resume", panel_vdd_en, 1);
        run_all = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule